// File: doc/BRIEF.md
# Eight-Level Vectored Interrupt Controller

This block gathers interrupt requests for a small 4-bit microcontroller core and turns them into one vectored call. It has eight priority levels. Level 0 ranks lowest and level 7 ranks highest. Hardware events feed six of the levels: pin edges, two timers, a serial buffer event and a voltage monitor. All eight levels can also be set by software through a write port that loads the pending register.

The block picks the highest pending level that is above every level already in service. It asserts a request and presents that level and its fixed ROM vector. The core acknowledges to take the call and pulses a return strobe when the service routine ends. A higher level can therefore interrupt a routine that is running, while lower or equal levels wait until it returns.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `pend_o` is 0 and `irq_o` is 0. All pin edge modes and all source enables are cleared, so pin toggles and event pulses set nothing until `cfg_wdata_i` is written.
- R2: When `irq_o` is 1, `irq_lvl_o` is the highest set bit of `pend_o`.
- R3: The vectors are fixed. Levels 0 to 6 use (level+1)*40h, giving 040h, 080h, 0C0h, 100h, 140h, 180h and 1C0h. Level 7 uses 1E0h.
- R4: A write on `swi_we_i` replaces `pend_o` with `swi_data_i` at the next clock edge. It can raise any level, including levels 0 and 5, which have no hardware source, and it can clear bits.
- R5: Each pin p has a 2-bit mode in `cfg_wdata_i[2p+1:2p]`: 0 is off, 1 is rising, 2 is falling and 3 is any edge. Pins 0 and 1 feed level 1, pins 2 and 3 feed level 3, and pins 4 and 5 feed level 6. A matching pin change sets the pending bit on the third clock edge after the change.
- R6: Four enable bits control the event inputs. Bit 12 enables timer 1 to level 2, bit 13 enables timer 2 to level 4, bit 14 enables the serial event to level 3, and bit 15 enables the voltage monitor to level 7. An enabled pulse sets its bit at the next edge. A disabled pulse has no effect.
- R7: When `ack_i` is high while `irq_o` is 1, the granted pending bit is cleared and that level is marked as in service. `ack_i` has no effect while `irq_o` is 0.
- R8: `irq_o` is asserted only for a pending level above every in-service level. `ret_i` removes the highest in-service level.
- R9: A hardware event sets its pending bit even if a software write or an acknowledge clear of the same bit happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 6 | Asynchronous external interrupt pins |
| tmr1_evt_i | input | 1 | Timer 1 event pulse |
| tmr2_evt_i | input | 1 | Timer 2 compare/overflow pulse |
| ser_evt_i | input | 1 | Serial buffer full/empty pulse |
| vmon_evt_i | input | 1 | Voltage monitor pulse |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Pin modes [11:0] and source enables [15:12] |
| swi_we_i | input | 1 | Pending register write strobe |
| swi_data_i | input | 8 | Pending register write data |
| ack_i | input | 1 | Core takes the current request |
| ret_i | input | 1 | Core leaves the current service routine |
| irq_o | output | 1 | Request to the core |
| irq_lvl_o | output | 3 | Requested level |
| vec_o | output | 9 | ROM vector of the requested level |
| pend_o | output | 8 | Pending register read value |

## Verification
Each result has a fixed delay. Software writes, event pulses, acknowledges and returns take effect one clock edge later. A pin change takes three edges: two for synchronization and one for the pending flop. The request, level and vector follow the registers combinationally. The bench drives every input on the falling edge and reads the outputs on a later falling edge, after exactly the number of rising edges each result needs. For pins it also checks, one edge early, that the bit is still clear.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_LVL  = 8;
  localparam int LVL_W    = $clog2(NUM_LVL);
  localparam int VEC_W    = 9;
  localparam int VEC_SH   = 6;
  localparam int NUM_PINS = 6;
  localparam int MODE_W   = 2;
  localparam int NUM_EN   = 4;
  localparam int CFG_W    = NUM_PINS * MODE_W + NUM_EN;
  localparam logic [VEC_W-1:0] TOP_VEC = 9'h1E0;

  typedef enum logic [MODE_W-1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  function automatic logic [VEC_W-1:0] vec_of(input logic [LVL_W-1:0] lvl);
    if (lvl == LVL_W'(NUM_LVL - 1)) return TOP_VEC;
    return (VEC_W'(lvl) + VEC_W'(1)) << VEC_SH;
  endfunction
endpackage

// File: rtl/vic_edge_det.sv
module vic_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  output logic       evt_o
);
  import vic_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;
  logic                   rise, fall;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= pin_i;
        else sync_q[s] <= sync_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= cur;
  end

  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;

  always_comb begin
    unique case (edge_mode_e'(mode_i))
      EDGE_RISE: evt_o = rise;
      EDGE_FALL: evt_o = fall;
      EDGE_ANY:  evt_o = rise | fall;
      default:   evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         vld_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
  assign vld_o = |req_i;
endmodule

// File: rtl/vic_pend_reg.sv
module vic_pend_reg #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hw_set_i,
  input  logic         sw_we_i,
  input  logic [N-1:0] sw_data_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q, pend_d;

  // software write overrides ack clear; hardware set wins over both
  assign pend_d = (sw_we_i ? sw_data_i : (pend_q & ~clr_i)) | hw_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                tmr1_evt_i,
  input  logic                tmr2_evt_i,
  input  logic                ser_evt_i,
  input  logic                vmon_evt_i,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  input  logic                swi_we_i,
  input  logic [NUM_LVL-1:0]  swi_data_i,
  input  logic                ack_i,
  input  logic                ret_i,
  output logic                irq_o,
  output logic [LVL_W-1:0]    irq_lvl_o,
  output logic [VEC_W-1:0]    vec_o,
  output logic [NUM_LVL-1:0]  pend_o
);
  localparam int MODE_BITS = NUM_PINS * MODE_W;

  logic [MODE_BITS-1:0] mode_q;
  logic [NUM_EN-1:0]    en_q;
  logic [NUM_PINS-1:0]  pin_evt;
  logic [NUM_LVL-1:0]   hw_set;
  logic [NUM_LVL-1:0]   isr_q, isr_d;
  logic [NUM_LVL-1:0]   ack_clr, ret_clr;
  logic                 pend_vld, isr_vld, take;
  logic [LVL_W-1:0]     pend_idx, isr_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      en_q   <= '0;
    end else if (cfg_we_i) begin
      mode_q <= cfg_wdata_i[MODE_BITS-1:0];
      en_q   <= cfg_wdata_i[CFG_W-1:MODE_BITS];
    end
  end

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      vic_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i[p]),
        .mode_i (mode_q[p*MODE_W +: MODE_W]),
        .evt_o  (pin_evt[p])
      );
    end
  endgenerate

  always_comb begin
    hw_set    = '0;
    hw_set[1] = pin_evt[0] | pin_evt[1];
    hw_set[2] = tmr1_evt_i & en_q[0];
    hw_set[3] = pin_evt[2] | pin_evt[3] | (ser_evt_i & en_q[2]);
    hw_set[4] = tmr2_evt_i & en_q[1];
    hw_set[6] = pin_evt[4] | pin_evt[5];
    hw_set[7] = vmon_evt_i & en_q[3];
  end

  vic_pend_reg #(.N(NUM_LVL)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_set_i  (hw_set),
    .sw_we_i   (swi_we_i),
    .sw_data_i (swi_data_i),
    .clr_i     (ack_clr),
    .pend_o    (pend_o)
  );

  vic_prio_enc #(.N(NUM_LVL), .W(LVL_W)) u_pend_enc (
    .req_i (pend_o),
    .vld_o (pend_vld),
    .idx_o (pend_idx)
  );

  vic_prio_enc #(.N(NUM_LVL), .W(LVL_W)) u_isr_enc (
    .req_i (isr_q),
    .vld_o (isr_vld),
    .idx_o (isr_idx)
  );

  assign irq_o     = pend_vld && (!isr_vld || pend_idx > isr_idx);
  assign irq_lvl_o = pend_idx;
  assign vec_o     = irq_o ? vec_of(pend_idx) : '0;
  assign take      = ack_i & irq_o;
  assign ack_clr   = take ? (NUM_LVL'(1) << pend_idx) : '0;
  assign ret_clr   = (ret_i && isr_vld) ? (NUM_LVL'(1) << isr_idx) : '0;
  assign isr_d     = (isr_q & ~ret_clr) | ack_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else isr_q <= isr_d;
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk
  import vic_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               irq_o,
  input logic [LVL_W-1:0]   irq_lvl_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [NUM_LVL-1:0] pend_o,
  input logic               ack_i,
  input logic               swi_we_i,
  input logic [NUM_LVL-1:0] hw_set,
  input logic [NUM_LVL-1:0] isr_q
);
  a_r2_granted_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_o[irq_lvl_o]);

  a_r2_none_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (((pend_o >> irq_lvl_o) >> 1) == '0));

  a_r3_vec_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[4:0] == '0 && vec_o != '0));

  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !swi_we_i && hw_set == '0) |=> !pend_o[$past(irq_lvl_o)]);

  a_r8_above_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((isr_q >> irq_lvl_o) == '0));

  a_r9_hw_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set != '0) |=> ((pend_o & $past(hw_set)) == $past(hw_set)));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_o     (irq_o),
  .irq_lvl_o (irq_lvl_o),
  .vec_o     (vec_o),
  .pend_o    (pend_o),
  .ack_i     (ack_i),
  .swi_we_i  (swi_we_i),
  .hw_set    (hw_set),
  .isr_q     (isr_q)
);

// File: tb/vec_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] pin = '0;
  logic       tmr1 = 0, tmr2 = 0, ser = 0, vmon = 0;
  logic       cfg_we = 0;
  logic [15:0] cfg_wd = '0;
  logic       swi_we = 0;
  logic [7:0] swi_d = '0;
  logic       ack = 0, ret = 0;
  logic       irq;
  logic [2:0] lvl;
  logic [8:0] vec;
  logic [7:0] pend;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin),
    .tmr1_evt_i(tmr1), .tmr2_evt_i(tmr2), .ser_evt_i(ser), .vmon_evt_i(vmon),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .swi_we_i(swi_we), .swi_data_i(swi_d),
    .ack_i(ack), .ret_i(ret),
    .irq_o(irq), .irq_lvl_o(lvl), .vec_o(vec), .pend_o(pend)
  );

  // {swi data[20:13], irq[12], level[11:9], vector[8:0]}
  localparam logic [20:0] VTBL [12] = '{
    {8'h01, 1'b1, 3'd0, 9'h040}, {8'h02, 1'b1, 3'd1, 9'h080},
    {8'h04, 1'b1, 3'd2, 9'h0C0}, {8'h08, 1'b1, 3'd3, 9'h100},
    {8'h10, 1'b1, 3'd4, 9'h140}, {8'h20, 1'b1, 3'd5, 9'h180},
    {8'h40, 1'b1, 3'd6, 9'h1C0}, {8'h80, 1'b1, 3'd7, 9'h1E0},
    {8'h00, 1'b0, 3'd0, 9'h000}, {8'h21, 1'b1, 3'd5, 9'h180},
    {8'hA5, 1'b1, 3'd7, 9'h1E0}, {8'h1E, 1'b1, 3'd4, 9'h140}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic swi(input logic [7:0] d);
    @(negedge clk); swi_we = 1; swi_d = d;
    @(negedge clk); swi_we = 0;
  endtask

  task automatic cfg(input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_wd = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic do_ret();
    @(negedge clk); ret = 1;
    @(negedge clk); ret = 0;
  endtask

  // pin change: pending still clear after 2 edges, set after the 3rd
  task automatic pin_case(input string req, input int p, input logic v, input logic [7:0] exp);
    @(negedge clk); pin[p] = v;
    cyc(2);
    chk({req, " early"}, pend, 0);
    cyc(1);
    chk(req, pend, exp);
    swi(8'h00);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R1 reset pend", pend, 0);
    chk("R1 reset irq", irq, 0);
    // R1: sources disabled after reset
    @(negedge clk); pin = 6'h3F; tmr1 = 1; tmr2 = 1; ser = 1; vmon = 1;
    @(negedge clk); tmr1 = 0; tmr2 = 0; ser = 0; vmon = 0;
    cyc(3);
    chk("R1 sources off", pend, 0);
    @(negedge clk); pin = '0;
    cyc(4);

    // R2 R3 R4 table walk
    for (int k = 0; k < 12; k++) begin
      swi(VTBL[k][20:13]);
      chk("R4 pend write", pend, VTBL[k][20:13]);
      chk("R2 irq", irq, VTBL[k][12]);
      if (VTBL[k][12]) begin
        chk("R2 level", lvl, VTBL[k][11:9]);
        chk("R3 vector", vec, VTBL[k][8:0]);
      end
    end
    swi(8'hFF);
    swi(8'h00);
    chk("R4 clear by write", pend, 0);

    // R5 pin modes: p0 rise, p1 fall, p2 any, others off
    cfg(16'h0039);
    pin_case("R5 p0 rise", 0, 1'b1, 8'h02);
    pin_case("R5 p0 fall ignored", 0, 1'b0, 8'h00);
    pin_case("R5 p1 rise ignored", 1, 1'b1, 8'h00);
    pin_case("R5 p1 fall", 1, 1'b0, 8'h02);
    pin_case("R5 p2 rise", 2, 1'b1, 8'h08);
    pin_case("R5 p2 fall", 2, 1'b0, 8'h08);
    pin_case("R5 p4 off", 4, 1'b1, 8'h00);
    cfg(16'h0C00);
    pin_case("R5 p5 any", 5, 1'b1, 8'h40);

    // R6 event enables
    @(negedge clk); tmr1 = 1;
    @(negedge clk); tmr1 = 0;
    chk("R6 tmr1 disabled", pend, 0);
    cfg(16'hF000);
    @(negedge clk); tmr1 = 1;
    @(negedge clk); tmr1 = 0;
    chk("R6 tmr1 lvl2", pend, 8'h04);
    @(negedge clk); tmr2 = 1; ser = 1;
    @(negedge clk); tmr2 = 0; ser = 0;
    chk("R6 tmr2 ser", pend, 8'h1C);
    @(negedge clk); vmon = 1;
    @(negedge clk); vmon = 0;
    chk("R6 vmon lvl7", pend, 8'h9C);
    swi(8'h00);

    // R7 ack clears, ack ignored with no request
    do_ack();
    chk("R7 ack idle", pend, 0);
    swi(8'h02);
    do_ack();
    chk("R7 ack clear", pend, 0);
    chk("R7 in service", irq, 0);
    // R8 nesting
    swi(8'h01);
    chk("R8 lower waits", irq, 0);
    swi(8'h41);
    chk("R8 higher preempts", irq, 1);
    chk("R8 higher level", lvl, 6);
    do_ack();
    chk("R8 nested ack", pend, 8'h01);
    chk("R8 nested irq", irq, 0);
    do_ret();
    chk("R8 after ret6", irq, 0);
    do_ret();
    chk("R8 after ret1", irq, 1);
    chk("R8 level0", lvl, 0);
    chk("R3 vector0", vec, 9'h040);
    swi(8'h00);

    // R9 collisions
    @(negedge clk); swi_we = 1; swi_d = 8'h01; tmr1 = 1;
    @(negedge clk); swi_we = 0; tmr1 = 0;
    chk("R9 hw vs swi", pend, 8'h05);
    swi(8'h04);
    @(negedge clk); ack = 1; tmr1 = 1;
    @(negedge clk); ack = 0; tmr1 = 0;
    chk("R9 hw vs ack", pend, 8'h04);
    chk("R9 equal waits", irq, 0);
    do_ret();
    chk("R9 after ret", irq, 1);
    chk("R9 level2", lvl, 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule